// File: doc/BRIEF.md
# Power-Up Protocol Mode Selector

This block picks, once per power cycle, which of two serial link protocols a memory device will speak. It watches the device's reset pin against the device's clock, starting from a single-cycle power-on pulse. If reset is already high at the first clock after power-on, the block selects the synchronous two-wire mode. If reset is held low for exactly a set number of clocks and then rises, the block selects the asynchronous smart-card mode. Any other reset timing is a fault, and the link stays dead until the next power-on.

In the asynchronous mode the block drives a fixed 64-bit answer-to-reset word onto the data line. The word is sent least-significant bit first, and each bit is held for a configurable number of clocks. The word carries a density code chosen by the integrator. In the synchronous mode the block holds off the command logic until the required warm-up clocks have been seen. Once a mode is chosen, it stays locked until the next power-on pulse.

Top module: `pmsel_top`

## Requirements
- R1: While `por` is high, the block clears the lock, the warm-up count and the answer-to-reset state. One clock edge later `link_mode` reads 2'b00 (undecided), `cmd_ready` is 0 and `io_oe` is 0.
- R2: If `rst_line` is high at the first clock edge after `por` falls, `link_mode` becomes 2'b01 (synchronous) after that edge.
- R3: If `rst_line` is sampled low at exactly RESET_DELAY (default 400) consecutive edges after `por` falls and is then sampled high, `link_mode` becomes 2'b10 (asynchronous) after the edge that sees it high.
- R4: Any other count of low samples before the first high sample sets `link_mode` to 2'b11 (fault). In the fault mode `cmd_ready` stays 0 and the data line is never driven.
- R5: Once `link_mode` is not 2'b00, later changes on `rst_line` have no effect on `link_mode` until the next `por`.
- R6: In the synchronous mode, `cmd_ready` rises after the WARMUP_PULSES-th (default 5) clock edge that follows the edge selecting the mode, and not earlier.
- R7: In the asynchronous mode, the answer-to-reset transmission starts at the edge after the mode is selected. Bit i of ATR_WORD appears on `io_out` with `io_oe`=1 for the BIT_CLKS edges starting at edge 1+i*BIT_CLKS. Bits are sent least-significant first.
- R8: `io_oe` is 0 whenever no answer-to-reset bit is being sent. This covers the undecided, synchronous and fault modes, and the asynchronous mode before and after the word.
- R9: In the asynchronous mode, `cmd_ready` rises at the edge that ends the last bit period (edge 1+64*BIT_CLKS after selection). At the same edge the data line is released.
- R10: A `por` pulse during a transmission aborts it. Afterwards a fresh selection works as it would after a first power-up.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Device clock line, used as the block's clock |
| por | input | 1 | Power-on pulse, synchronous, active high |
| rst_line | input | 1 | Device reset pin as seen by the block |
| link_mode | output | 2 | 00 undecided, 01 synchronous, 10 asynchronous, 11 fault |
| cmd_ready | output | 1 | High when the command logic may accept a first command |
| io_oe | output | 1 | Data-line drive enable; 0 leaves the line to the pull-up |
| io_out | output | 1 | Level driven on the data line when `io_oe` is 1 |

## Verification
The assertions assume that `por` is high from time zero for at least one clock edge, and that `rst_line` changes only between clock edges, so each edge sees one clean level. The bench drives every input on the falling edge and always opens a run with a power-on pulse, so both assumptions hold. Reset-low lengths are drawn from a seeded generator. They are weighted toward the exact delay, its two neighbours and zero, so the lock, fault and transmission properties are all reached while the inputs stay within these limits.

// File: rtl/pmsel_pkg.sv
package pmsel_pkg;

    typedef enum logic [1:0] {
        MODE_UNDECIDED = 2'b00,
        MODE_SYNC      = 2'b01,
        MODE_ASYNC     = 2'b10,
        MODE_FAULT     = 2'b11
    } link_mode_e;

    typedef enum logic [1:0] {
        TX_IDLE = 2'b00,
        TX_SEND = 2'b01,
        TX_DONE = 2'b10
    } atr_state_e;

    typedef struct packed {
        logic drive;
        logic level;
    } line_drive_t;

    localparam int ATR_BITS = 64;

    // Density code placed in the top byte of the default answer word.
    localparam logic [7:0] DENSITY_CODE = 8'h14;

    function automatic logic [ATR_BITS-1:0] build_atr(input logic [7:0] density);
        return {density, 56'h5A_C3_0F_61_92_E4_3B};
    endfunction

    localparam logic [ATR_BITS-1:0] ATR_DEFAULT = build_atr(DENSITY_CODE);

    function automatic logic is_locked(input link_mode_e m);
        return m != MODE_UNDECIDED;
    endfunction

endpackage

// File: rtl/pmsel_reset_timer.sv
module pmsel_reset_timer
    import pmsel_pkg::*;
#(
    parameter int RESET_DELAY = 400
) (
    input  logic       clk,
    input  logic       por,
    input  logic       rst_line,
    output link_mode_e mode
);
    localparam int CW = $clog2(RESET_DELAY + 2);
    localparam logic [CW-1:0] CNT_EXACT = CW'(RESET_DELAY);
    localparam logic [CW-1:0] CNT_SAT   = CW'(RESET_DELAY + 1);

    logic [CW-1:0] low_cnt;

    always_ff @(posedge clk) begin
        if (por) begin
            mode    <= MODE_UNDECIDED;
            low_cnt <= '0;
        end else if (!is_locked(mode)) begin
            if (rst_line) begin
                if (low_cnt == '0)
                    mode <= MODE_SYNC;
                else if (low_cnt == CNT_EXACT)
                    mode <= MODE_ASYNC;
                else
                    mode <= MODE_FAULT;
            end else if (low_cnt != CNT_SAT) begin
                low_cnt <= low_cnt + 1'b1;
            end
        end
    end

    AST_MODE_STICKY: assert property (@(posedge clk) disable iff (por)
        is_locked(mode) |=> (mode == $past(mode))); // R5

    AST_ASYNC_EXACT: assert property (@(posedge clk) disable iff (por)
        (mode == MODE_ASYNC && $past(mode) == MODE_UNDECIDED)
            |-> ($past(low_cnt) == CNT_EXACT)); // R3

    AST_SYNC_NO_LOW: assert property (@(posedge clk) disable iff (por)
        (mode == MODE_SYNC && $past(mode) == MODE_UNDECIDED)
            |-> ($past(low_cnt) == '0)); // R2

endmodule

// File: rtl/pmsel_warmup.sv
module pmsel_warmup #(
    parameter int WARMUP_PULSES = 5
) (
    input  logic clk,
    input  logic por,
    input  logic enable,
    output logic ready
);
    localparam int WW = $clog2(WARMUP_PULSES + 1);
    localparam logic [WW-1:0] WARM_MAX = WW'(WARMUP_PULSES);

    logic [WW-1:0] pulse_cnt;

    always_ff @(posedge clk) begin
        if (por)
            pulse_cnt <= '0;
        else if (enable && pulse_cnt != WARM_MAX)
            pulse_cnt <= pulse_cnt + 1'b1;
    end

    assign ready = (pulse_cnt == WARM_MAX);

    AST_WARM_NO_OVERFLOW: assert property (@(posedge clk) disable iff (por)
        pulse_cnt <= WARM_MAX); // R6

    AST_WARM_NEEDS_ENABLE: assert property (@(posedge clk) disable iff (por)
        $rose(ready) |-> $past(enable)); // R6

endmodule

// File: rtl/pmsel_atr_tx.sv
module pmsel_atr_tx
    import pmsel_pkg::*;
#(
    parameter logic [ATR_BITS-1:0] ATR_WORD = ATR_DEFAULT,
    parameter int BIT_CLKS = 4
) (
    input  logic        clk,
    input  logic        por,
    input  logic        start,
    output line_drive_t drv,
    output logic        done
);
    localparam int BW = $clog2(ATR_BITS);
    localparam int PW = $clog2(BIT_CLKS + 1);
    localparam logic [BW-1:0] LAST_BIT = BW'(ATR_BITS - 1);
    localparam logic [PW-1:0] LAST_CYC = PW'(BIT_CLKS - 1);

    atr_state_e          state;
    logic [ATR_BITS-1:0] shreg;
    logic [BW-1:0]       bit_idx;
    logic [PW-1:0]       cyc;

    always_ff @(posedge clk) begin
        if (por) begin
            state   <= TX_IDLE;
            shreg   <= '0;
            bit_idx <= '0;
            cyc     <= '0;
        end else begin
            unique case (state)
                TX_IDLE: begin
                    if (start) begin
                        state   <= TX_SEND;
                        shreg   <= ATR_WORD;
                        bit_idx <= '0;
                        cyc     <= '0;
                    end
                end
                TX_SEND: begin
                    if (cyc == LAST_CYC) begin
                        cyc   <= '0;
                        shreg <= shreg >> 1;
                        if (bit_idx == LAST_BIT)
                            state <= TX_DONE;
                        else
                            bit_idx <= bit_idx + 1'b1;
                    end else begin
                        cyc <= cyc + 1'b1;
                    end
                end
                default: state <= TX_DONE;
            endcase
        end
    end

    always_comb begin
        drv.drive = (state == TX_SEND);
        drv.level = (state == TX_SEND) ? shreg[0] : 1'b1;
    end

    assign done = (state == TX_DONE);

    AST_TX_PERIOD_RANGE: assert property (@(posedge clk) disable iff (por)
        (state == TX_SEND) |-> (cyc <= LAST_CYC)); // R7

    AST_TX_ORDER: assert property (@(posedge clk) disable iff (por)
        (state == TX_SEND && $past(state) == TX_SEND && $past(cyc) != LAST_CYC)
            |-> $stable(bit_idx)); // R7

    AST_TX_DONE_STICKY: assert property (@(posedge clk) disable iff (por)
        (state == TX_DONE) |=> (state == TX_DONE)); // R9

endmodule

// File: rtl/pmsel_top.sv
module pmsel_top
    import pmsel_pkg::*;
#(
    parameter int RESET_DELAY   = 400,
    parameter int WARMUP_PULSES = 5,
    parameter int BIT_CLKS      = 4,
    parameter logic [ATR_BITS-1:0] ATR_WORD = ATR_DEFAULT
) (
    input  logic       clk,
    input  logic       por,
    input  logic       rst_line,
    output logic [1:0] link_mode,
    output logic       cmd_ready,
    output logic       io_oe,
    output logic       io_out
);
    link_mode_e  mode;
    logic        warm_ready;
    logic        atr_done;
    line_drive_t drv;

    pmsel_reset_timer #(.RESET_DELAY(RESET_DELAY)) u_timer (
        .clk      (clk),
        .por      (por),
        .rst_line (rst_line),
        .mode     (mode)
    );

    pmsel_warmup #(.WARMUP_PULSES(WARMUP_PULSES)) u_warm (
        .clk    (clk),
        .por    (por),
        .enable (mode == MODE_SYNC),
        .ready  (warm_ready)
    );

    pmsel_atr_tx #(.ATR_WORD(ATR_WORD), .BIT_CLKS(BIT_CLKS)) u_atr (
        .clk   (clk),
        .por   (por),
        .start (mode == MODE_ASYNC),
        .drv   (drv),
        .done  (atr_done)
    );

    always_comb begin
        link_mode = mode;
        unique case (mode)
            MODE_SYNC:  cmd_ready = warm_ready;
            MODE_ASYNC: cmd_ready = atr_done;
            default:    cmd_ready = 1'b0;
        endcase
        io_oe  = drv.drive;
        io_out = drv.level;
    end

    AST_DRIVE_ONLY_ASYNC: assert property (@(posedge clk) disable iff (por)
        io_oe |-> (mode == MODE_ASYNC)); // R8

    AST_READY_NEEDS_MODE: assert property (@(posedge clk) disable iff (por)
        cmd_ready |-> (mode == MODE_SYNC || mode == MODE_ASYNC)); // R4

    AST_READY_LINE_FREE: assert property (@(posedge clk) disable iff (por)
        cmd_ready |-> !io_oe); // R9

    AST_ONE_SIDE_ONLY: assert property (@(posedge clk) disable iff (por)
        !(warm_ready && atr_done)); // R5

endmodule

// File: tb/tb_pmsel_top.sv
module tb_pmsel_top;
    localparam int CLK_PERIOD = 10;
    localparam int DELAY      = 400;
    localparam int WARM       = 5;
    localparam int BCLK       = 3;
    localparam logic [63:0] ATR_TB = 64'h14_5A_C3_0F_61_92_E4_3B;

    logic       clk = 1'b0;
    logic       por = 1'b1;
    logic       rst_line = 1'b0;
    logic [1:0] link_mode;
    logic       cmd_ready;
    logic       io_oe;
    logic       io_out;

    int checks = 0;
    int failures = 0;
    bit finished = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    pmsel_top #(
        .RESET_DELAY(DELAY), .WARMUP_PULSES(WARM),
        .BIT_CLKS(BCLK), .ATR_WORD(ATR_TB)
    ) dut (
        .clk(clk), .por(por), .rst_line(rst_line),
        .link_mode(link_mode), .cmd_ready(cmd_ready),
        .io_oe(io_oe), .io_out(io_out)
    );

    task automatic chk(input bit ok, input string tag, input logic [63:0] act,
                       input logic [63:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic logic [1:0] exp_mode(input int low_len);
        if (low_len == 0)     return 2'b01;
        if (low_len == DELAY) return 2'b10;
        return 2'b11;
    endfunction

    task automatic finish_run();
        if (!finished) begin
            finished = 1'b1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    endtask

    // R1: pulse power-on, check cleared outputs, release
    task automatic power_on();
        @(negedge clk);
        por = 1'b1;
        rst_line = 1'b0;
        repeat (2) @(negedge clk);
        chk(link_mode == 2'b00 && !cmd_ready && !io_oe, "R1 por clears",
            {link_mode, cmd_ready, io_oe}, 64'h0);
        por = 1'b0;
    endtask

    // Hold reset low for low_len sampled edges, then raise it; returns one
    // negedge after the selecting edge.
    task automatic select(input int low_len);
        rst_line = 1'b0;
        repeat (low_len) @(negedge clk);
        rst_line = 1'b1;
        @(negedge clk);
    endtask

    task automatic follow_up(input logic [1:0] m);
        bit ok;
        if (m == 2'b01) begin
            for (int k = 1; k <= WARM; k++) begin
                @(negedge clk);
                if (k < WARM)
                    chk(!cmd_ready && !io_oe, "R6 not ready during warm-up", cmd_ready, 0);
                else
                    chk(cmd_ready && !io_oe, "R6 ready after warm-up", cmd_ready, 1);
            end
        end else if (m == 2'b10) begin
            chk(!io_oe, "R8 line free at selection", io_oe, 0);
            for (int i = 0; i < 64; i++) begin
                ok = 1'b1;
                for (int c = 0; c < BCLK; c++) begin
                    @(negedge clk);
                    if (!(io_oe && io_out == ATR_TB[i] && !cmd_ready)) ok = 1'b0;
                end
                chk(ok, "R7 ATR bit", {io_oe, io_out}, {1'b1, ATR_TB[i]});
            end
            @(negedge clk);
            chk(cmd_ready && !io_oe, "R9 ready after ATR", {cmd_ready, io_oe}, 2'b10);
        end else begin
            ok = 1'b1;
            repeat (20) begin
                @(negedge clk);
                if (cmd_ready || io_oe) ok = 1'b0;
            end
            chk(ok, "R4 fault stays quiet", {cmd_ready, io_oe}, 0);
        end
    endtask

    // R5: wiggle the reset pin after lock
    task automatic wiggle_lock(input logic [1:0] m);
        bit ok = 1'b1;
        rst_line = 1'b0;
        repeat (DELAY) @(negedge clk);
        rst_line = 1'b1;
        repeat (3) begin
            @(negedge clk);
            if (link_mode != m) ok = 1'b0;
        end
        chk(ok, "R5 mode locked", link_mode, m);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        checks++;
        failures++;
        $display("FAIL watchdog expired actual=timeout expected=finish");
        finish_run();
    end

    initial begin
        int len;
        int pick;
        void'($urandom(32'd7151));

        // Directed: synchronous default
        power_on();
        select(0);
        chk(link_mode == 2'b01, "R2 sync at power-up", link_mode, 2'b01);
        follow_up(2'b01);
        wiggle_lock(2'b01);
        chk(!io_oe, "R8 sync never drives", io_oe, 0);

        // Directed: asynchronous exact delay
        power_on();
        select(DELAY);
        chk(link_mode == 2'b10, "R3 async at exact delay", link_mode, 2'b10);
        follow_up(2'b10);
        wiggle_lock(2'b10);
        chk(!io_oe && cmd_ready, "R8 released after ATR", {io_oe, cmd_ready}, 2'b01);

        // Directed: one short, one long
        power_on();
        select(DELAY - 1);
        chk(link_mode == 2'b11, "R4 fault one short", link_mode, 2'b11);
        follow_up(2'b11);
        wiggle_lock(2'b11);
        power_on();
        select(DELAY + 1);
        chk(link_mode == 2'b11, "R4 fault one long", link_mode, 2'b11);

        // R10: abort mid-ATR, then fresh selection
        power_on();
        select(DELAY);
        repeat (50) @(negedge clk);
        power_on();
        chk(!io_oe, "R10 abort releases line", io_oe, 0);
        select(0);
        chk(link_mode == 2'b01, "R10 fresh selection", link_mode, 2'b01);
        follow_up(2'b01);

        // Constrained random trials
        for (int t = 0; t < 12; t++) begin
            pick = $urandom_range(0, 4);
            case (pick)
                0:       len = DELAY;
                1:       len = 0;
                2:       len = DELAY - 1;
                3:       len = DELAY + 1;
                default: len = $urandom_range(1, 700);
            endcase
            power_on();
            select(len);
            chk(link_mode == exp_mode(len), "R2 R3 R4 random selection",
                link_mode, exp_mode(len));
            follow_up(exp_mode(len));
        end

        finish_run();
    end
endmodule